// File: doc/BRIEF.md
# UART Receiver with Status-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It watches an oversampled serial line and detects the start of each frame. It then recovers the data bits, an optional parity bit and the stop bit. The finished word goes into a receive queue together with three error flags that belong to that word. Software or a downstream engine pops words one at a time and sees each word beside the errors found while it was being received. The flags are tied to the word itself, not to the moment it is read.

A mode input selects the storage behaviour. With the mode input set, the queue holds up to eight words. With it clear, the block acts as a single holding register. In both modes, a word that arrives when there is no room is thrown away, and a sticky overrun indication is raised. A separate clear strobe removes that indication. The baud tick is generated outside the block and pulses sixteen times per bit period.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `overrun` is 0.
- R2: A frame is sent LSB first and is made of a low start bit, then the data bits, then one parity bit if `parity_en` is 1, then one stop bit. The number of data bits comes from `word_len`: 00 gives 8, 01 gives 9, 10 gives 7 and 11 gives 8. Each bit lasts 16 ticks of `sample_tick`. The tick on which the idle line is first seen low counts as tick 0 of the start bit.
- R3: Each bit value is the majority of the line samples taken at ticks 7, 8 and 9 of that bit. The word appears on `rd_word[8:0]`, and the bits above the word length read as zero.
- R4: Parity is even: the data bits plus the parity bit must contain an even number of ones. When `parity_en` is 1 and this check fails, `rd_word[9]` is 1 for that word. When `parity_en` is 0, `rd_word[9]` is 0.
- R5: `rd_word[10]` is 1 for a word whose stop bit resolves low.
- R6: `rd_word[11]` is 1 for a word in which the three samples of any data, parity or stop bit do not all agree.
- R7: If the line is high at tick 8 of a start bit, the receiver drops the frame, returns to idle and stores no word.
- R8: With `fifo_en` at 1, up to 8 words are held and are read back in arrival order. `full` is 1 while 8 words are held. `rd_word` shows the oldest word whenever `empty` is 0, and a pulse on `rd_en` removes that word.
- R9: With `fifo_en` at 0, only one word is held, and `full` rises as soon as that word is stored.
- R10: A word that completes while the storage is full, with no read in the same cycle, is discarded and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed. The words already stored are not changed.
- R11: A pulse on `rd_en` while `empty` is 1 has no effect on the stored contents or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line, high when idle |
| sample_tick | input | 1 | Oversampling strobe, 16 per bit |
| word_len | input | 2 | Number of data bits (00=8, 01=9, 10=7, 11=8) |
| parity_en | input | 1 | Expect an even-parity bit after the data bits |
| fifo_en | input | 1 | 1 = eight-entry queue, 0 = single holding register |
| rd_en | input | 1 | Pop the oldest word |
| ovr_clr | input | 1 | Clear the overrun indication |
| rd_word | output | 12 | Oldest entry: [8:0] data, [9] parity error, [10] framing error, [11] noise |
| empty | output | 1 | No word stored |
| full | output | 1 | No room for another word |
| overrun | output | 1 | Sticky: a word was discarded |

## Verification
A wrong sample position or a wrong bit counter shows up directly in the word that is read back. The data ends up shifted, or the tags are set wrongly, as soon as the first frame is popped, about 180 ticks after that frame begins. Errors in the queue pointers or the occupancy count show up as words returned out of order, as `full` rising at the wrong fill level, or as `empty` staying clear after every word has been read. An overrun that is lost or raised too early shows on `overrun` right after the ninth frame, or right after the second frame in single-register mode.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int WORD_MAX = 9;

    typedef struct packed {
        logic                noise;
        logic                ferr;
        logic                perr;
        logic [WORD_MAX-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    function automatic logic [3:0] bits_for_len(input logic [1:0] len);
        case (len)
            2'b01:   return 4'd9;
            2'b10:   return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [WORD_MAX-1:0] right_align(input logic [WORD_MAX-1:0] sh,
                                                         input logic [3:0] n);
        return sh >> (4'(WORD_MAX) - n);
    endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rxd,
    input  logic      tick,
    input  logic [1:0] word_len,
    input  logic      parity_en,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [3:0]          nbits;
    logic [3:0]          bitn;
    logic [WORD_MAX-1:0] shreg;
    logic                smp_a, smp_b;
    logic                par_acc, perr_q, noise_acc, par_on;
    logic                bit_v, bit_nz, at_decide, at_end;

    always_comb begin
        bit_v     = vote3(smp_a, smp_b, rxd);
        bit_nz    = !((smp_a == smp_b) && (smp_b == rxd));
        at_decide = (cnt == CW'(MID + 1));
        at_end    = (cnt == CW'(OSR - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            nbits     <= 4'd8;
            bitn      <= '0;
            shreg     <= '0;
            smp_a     <= 1'b1;
            smp_b     <= 1'b1;
            par_acc   <= 1'b0;
            perr_q    <= 1'b0;
            noise_acc <= 1'b0;
            par_on    <= 1'b0;
            push      <= 1'b0;
            entry     <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!rxd) begin
                        state     <= RX_START;
                        cnt       <= CW'(1);
                        nbits     <= bits_for_len(word_len);
                        par_on    <= parity_en;
                        bitn      <= '0;
                        par_acc   <= 1'b0;
                        perr_q    <= 1'b0;
                        noise_acc <= 1'b0;
                    end
                end else begin
                    cnt <= at_end ? '0 : cnt + CW'(1);
                    if (cnt == CW'(MID - 1)) smp_a <= rxd;
                    if (cnt == CW'(MID))     smp_b <= rxd;
                    case (state)
                        RX_START: begin
                            if (cnt == CW'(MID) && rxd) begin
                                state <= RX_IDLE;
                                cnt   <= '0;
                            end else if (at_end) begin
                                state <= RX_DATA;
                            end
                        end
                        RX_DATA: begin
                            if (at_decide) begin
                                shreg     <= {bit_v, shreg[WORD_MAX-1:1]};
                                par_acc   <= par_acc ^ bit_v;
                                noise_acc <= noise_acc | bit_nz;
                                bitn      <= bitn + 4'd1;
                            end
                            if (at_end && bitn == nbits)
                                state <= par_on ? RX_PAR : RX_STOP;
                        end
                        RX_PAR: begin
                            if (at_decide) begin
                                perr_q    <= par_acc ^ bit_v;
                                noise_acc <= noise_acc | bit_nz;
                            end
                            if (at_end) state <= RX_STOP;
                        end
                        RX_STOP: begin
                            if (at_decide) begin
                                push        <= 1'b1;
                                entry.data  <= right_align(shreg, nbits);
                                entry.perr  <= par_on & perr_q;
                                entry.ferr  <= !bit_v;
                                entry.noise <= noise_acc | bit_nz;
                                state       <= RX_IDLE;
                                cnt         <= '0;
                            end
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
            end
        end
    end

    // R7: a high line at the mid-start sample aborts the frame
    assert_false_start_R7: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && cnt == CW'(MID) && rxd) |=> (state == RX_IDLE && !push));

    // R2: a word is only delivered out of the stop-bit phase
    assert_push_at_stop_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(state) == RX_STOP);

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_en,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      rd_en,
    input  logic      ovr_clr,
    output rx_entry_t rdata,
    output logic      empty,
    output logic      full,
    output logic      overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [NW-1:0] count, cap;
    logic          pop, accept, drop;

    always_comb begin
        cap    = fifo_en ? NW'(DEPTH) : NW'(1);
        empty  = (count == '0);
        full   = (count >= cap);
        pop    = rd_en && !empty;
        accept = push && (!full || pop);
        drop   = push && full && !pop;
        rdata  = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            count <= count + NW'(accept) - NW'(pop);
            if (drop)         overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end

    // R8: occupancy never exceeds the queue depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        count <= NW'(DEPTH));

    // R10: a discarded word raises the sticky indication
    assert_drop_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !rd_en) |=> overrun);

    // R10: the indication only falls on a clear strobe
    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    // R11: a read of an empty store changes nothing
    assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !push) |=> (empty && $stable(rd_ptr)));

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rxd,
    input  logic        sample_tick,
    input  logic [1:0]  word_len,
    input  logic        parity_en,
    input  logic        fifo_en,
    input  logic        rd_en,
    input  logic        ovr_clr,
    output logic [11:0] rd_word,
    output logic        empty,
    output logic        full,
    output logic        overrun
);
    rx_entry_t new_entry, head;
    logic      new_push;

    uart_rx_deser #(.OSR(OSR)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .rxd       (rxd),
        .tick      (sample_tick),
        .word_len  (word_len),
        .parity_en (parity_en),
        .push      (new_push),
        .entry     (new_entry)
    );

    rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .push    (new_push),
        .wdata   (new_entry),
        .rd_en   (rd_en),
        .ovr_clr (ovr_clr),
        .rdata   (head),
        .empty   (empty),
        .full    (full),
        .overrun (overrun)
    );

    assign rd_word = head;

    // R1: flags come out of reset in their idle state
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (empty && !full && !overrun));

endmodule

// File: tb/test_uart_rx_tagged.sv
module test_uart_rx_tagged;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        sample_tick = 1'b0;
    logic [1:0]  word_len = 2'b00;
    logic        parity_en = 1'b0;
    logic        fifo_en = 1'b1;
    logic        rd_en = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [11:0] rd_word;
    logic        empty, full, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rx_tagged i_uart_rx_tagged (
        .clk(clk), .rst(rst), .rxd(rxd), .sample_tick(sample_tick),
        .word_len(word_len), .parity_en(parity_en), .fifo_en(fifo_en),
        .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_word(rd_word),
        .empty(empty), .full(full), .overrun(overrun)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic line_tick(input logic v);
        @(negedge clk); rxd = v; sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) line_tick(1'b1);
    endtask

    // glitch: bit index (0 = start) whose tick 8 is inverted, -1 for none
    task automatic send(input logic [8:0] d, input int n, input bit pen, input bit bad_par,
                        input bit stop_v, input int glitch);
        logic [11:0] bits;
        logic [8:0]  dm;
        int          nb;
        dm = d & ((9'd1 << n) - 9'd1);
        bits = '0;
        nb = 0;
        bits[nb++] = 1'b0;
        for (int i = 0; i < n; i++) bits[nb++] = dm[i];
        if (pen) bits[nb++] = (^dm) ^ bad_par;
        bits[nb++] = stop_v;
        for (int b = 0; b < nb; b++)
            for (int j = 0; j < 16; j++)
                line_tick((b == glitch && j == 8) ? ~bits[b] : bits[b]);
        idle(20);
    endtask

    function automatic logic [11:0] tag(input logic [8:0] d, input int n, input bit pe,
                                        input bit fe, input bit nz);
        return {nz, fe, pe, d & ((9'd1 << n) - 9'd1)};
    endfunction

    task automatic pop_chk(input string t, input logic [11:0] exp);
        @(negedge clk);
        chk({t, " empty"}, empty, 1'b0);
        chk(t, rd_word, exp);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 empty", empty, 1'b1);
        chk("R1 full", full, 1'b0);
        chk("R1 overrun", overrun, 1'b0);
    endtask

    task automatic t_lengths;
        word_len = 2'b00; send(9'h0A5, 8, 0, 0, 1, -1);
        pop_chk("R2 R3 8-bit", tag(9'h0A5, 8, 0, 0, 0));
        word_len = 2'b10; send(9'h1DA, 7, 0, 0, 1, -1);
        pop_chk("R2 R3 7-bit", tag(9'h1DA, 7, 0, 0, 0));
        word_len = 2'b01; parity_en = 1; send(9'h1C3, 9, 1, 0, 1, -1);
        pop_chk("R2 R4 9-bit parity ok", tag(9'h1C3, 9, 0, 0, 0));
        word_len = 2'b11; parity_en = 0; send(9'h03C, 8, 0, 0, 1, -1);
        pop_chk("R2 len code 11", tag(9'h03C, 8, 0, 0, 0));
        chk("R3 empty after read", empty, 1'b1);
    endtask

    task automatic t_parity;
        word_len = 2'b00; parity_en = 1; send(9'h071, 8, 1, 1, 1, -1);
        pop_chk("R4 parity error", tag(9'h071, 8, 1, 0, 0));
        parity_en = 0;
    endtask

    task automatic t_framing;
        word_len = 2'b00; send(9'h0E1, 8, 0, 0, 0, -1);
        idle(20);
        pop_chk("R5 framing error", tag(9'h0E1, 8, 0, 1, 0));
        chk("R5 no spurious word", empty, 1'b1);
    endtask

    task automatic t_noise;
        word_len = 2'b00; send(9'h03C, 8, 0, 0, 1, 4);
        pop_chk("R6 noise data bit", tag(9'h03C, 8, 0, 0, 1));
        send(9'h055, 8, 0, 0, 1, 9);
        pop_chk("R6 noise stop bit", tag(9'h055, 8, 0, 0, 1));
    endtask

    task automatic t_false_start;
        for (int i = 0; i < 6; i++) line_tick(1'b0);
        idle(40);
        chk("R7 false start stores nothing", empty, 1'b1);
        send(9'h099, 8, 0, 0, 1, -1);
        pop_chk("R7 next frame intact", tag(9'h099, 8, 0, 0, 0));
    endtask

    task automatic t_fifo_overrun;
        fifo_en = 1; word_len = 2'b00;
        for (int k = 0; k < 8; k++) begin
            chk("R8 not full before 8", full, 1'b0);
            send(9'(8'h10 + k), 8, 0, 0, 1, -1);
        end
        chk("R8 full at 8", full, 1'b1);
        chk("R10 no overrun yet", overrun, 1'b0);
        send(9'h0EE, 8, 0, 0, 1, -1);
        chk("R10 overrun set", overrun, 1'b1);
        for (int k = 0; k < 8; k++) pop_chk("R8 R10 order", tag(9'(8'h10 + k), 8, 0, 0, 0));
        chk("R10 dropped word absent", empty, 1'b1);
        chk("R10 overrun sticky", overrun, 1'b1);
        @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        chk("R10 overrun cleared", overrun, 1'b0);
    endtask

    task automatic t_single;
        fifo_en = 0;
        send(9'h0A1, 8, 0, 0, 1, -1);
        chk("R9 full after one word", full, 1'b1);
        send(9'h0B2, 8, 0, 0, 1, -1);
        chk("R9 overrun on second word", overrun, 1'b1);
        pop_chk("R9 first word kept", tag(9'h0A1, 8, 0, 0, 0));
        chk("R9 empty after read", empty, 1'b1);
        @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        fifo_en = 1;
    endtask

    task automatic t_empty_read;
        @(negedge clk); rd_en = 1; @(negedge clk); @(negedge clk); rd_en = 0;
        chk("R11 still empty", empty, 1'b1);
        chk("R11 no overrun", overrun, 1'b0);
        send(9'h066, 8, 0, 0, 1, -1);
        chk("R11 one word not full", full, 1'b0);
        pop_chk("R11 word after empty read", tag(9'h066, 8, 0, 0, 0));
        chk("R11 empty after single pop", empty, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        idle(4);
        t_lengths();
        t_parity();
        t_framing();
        t_noise();
        t_false_start();
        t_fifo_overrun();
        t_single();
        t_empty_read();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule